// File: doc/BRIEF.md
# Sector ECC Error Report Correction Unit

This block takes the report produced by a 4-bit sector ECC decoder and applies it to a 512-byte sector kept in a local byte buffer. The report has three 32-bit words: two carry the error count and up to four byte positions, and the third packs one XOR pattern byte for each error. After a start pulse the block decodes the count. It then walks the reported errors in order, from the first upward. For each error that lands inside the valid payload, it reads the buffer byte and writes it back XORed with that error's pattern.

A valid-length input lets the same unit check short payloads that were padded with dummy 0xFF bytes before the syndrome was computed. An example is a 44-byte spare context padded out to a full sector. An error located in the padding ends the walk and is reported as clean. A position beyond the sector is skipped. When the walk ends, the block raises a one-cycle done pulse and a 2-bit status, which holds until the next accepted start. The buffer is loaded and read back through a simple host port. That port can write only while the unit is idle.

Top module: `sector_ecc_fix`

## Requirements
- R1: The error count is bits 28:26 of `err_loc_lo`. A count of 0 finishes with status 2'b00 (clean) and leaves every buffer byte unchanged.
- R2: A count of 5, 6 or 7 finishes with status 2'b10 (uncorrectable) and leaves every buffer byte unchanged.
- R3: Byte positions are 10-bit fields: error 1 is at `err_loc_lo[9:0]`, error 2 at `err_loc_lo[25:16]`, error 3 at `err_loc_hi[9:0]` and error 4 at `err_loc_hi[25:16]`.
- R4: The XOR pattern for error n is `err_pat[8n-1:8n-8]`, so error 1 uses bits 7:0 and error 4 uses bits 31:24.
- R5: An error whose position is below the valid length replaces the buffer byte at that position with itself XOR the pattern. When all counted errors are walked, the status is 2'b01 (corrected). Repeated positions compound, in order.
- R6: Only the first `count` errors are walked, in ascending order. Bytes named by later fields stay unchanged.
- R7: A position at or above the valid length but below 512 ends the walk at once with status 2'b00. Corrections already made stay applied, and later errors are not applied.
- R8: A position of 512 or more is skipped, and the walk goes on with the next error.
- R9: `busy` rises on the clock edge that accepts `start`. Each applied correction takes two cycles, each skipped error one cycle, and the final decision one cycle. On that last edge `done` pulses for one cycle and `busy` falls.
- R10: While `busy` is high, `start` and host writes are ignored. The report in progress and the buffer contents are unaffected.
- R11: After reset, `busy`, `done` and `status` are 0. `status` changes only together with `done` and holds until the next walk ends.
- R12: `valid_len` is captured at start. The value 512 treats the whole sector as data, and 44 marks bytes 44 to 511 as padding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a new report when idle |
| err_loc_lo | input | 32 | Count [28:26], error 2 position [25:16], error 1 position [9:0] |
| err_loc_hi | input | 32 | Error 4 position [25:16], error 3 position [9:0] |
| err_pat | input | 32 | Four XOR pattern bytes, error 1 in the low byte |
| valid_len | input | 10 | Number of real payload bytes (1 to 512) |
| busy | output | 1 | A report is being applied |
| done | output | 1 | One-cycle pulse at the end of a walk |
| status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| host_we | input | 1 | Buffer write strobe, honoured only while idle |
| host_waddr | input | 9 | Buffer write address |
| host_wdata | input | 8 | Buffer write data |
| host_raddr | input | 9 | Buffer read address |
| host_rdata | output | 8 | Buffer byte at `host_raddr`, combinational |

## Verification
The assertions check the following on every cycle: a write-back always follows its buffer read, no write-back lands at or beyond the valid length, no write-back happens for an out-of-range count, `done` is a single-cycle pulse that coincides with `busy` falling, `status` changes only with `done`, and a start during a walk leaves the captured report alone. The walk order, the stop on padding, the skip beyond the sector, the exact cycle counts and the XOR results in the buffer can be shown only by the bench scenarios. There, a behavioural model replays each report and is compared against the ports every cycle.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int SECT_BYTES = 512;
  localparam int MAX_FIX    = 4;
  localparam int WORD_W     = 32;
  localparam int POS_W      = 10;
  localparam int CNT_W      = 3;
  localparam int CNT_LSB    = 26;
  localparam int HI_LSB     = 16;
  localparam int PAT_W      = 8;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'b00,
    ST_FIXED  = 2'b01,
    ST_UNCORR = 2'b10
  } fix_status_e;

  typedef enum logic [1:0] {
    CL_APPLY = 2'd0,
    CL_PAD   = 2'd1,
    CL_SKIP  = 2'd2
  } entry_class_e;

  function automatic logic [CNT_W-1:0] report_count(input logic [WORD_W-1:0] w);
    return w[CNT_LSB +: CNT_W];
  endfunction

  function automatic logic [POS_W-1:0] half_pos(input logic [WORD_W-1:0] w, input logic upper);
    return upper ? w[HI_LSB +: POS_W] : w[0 +: POS_W];
  endfunction

  function automatic entry_class_e classify(input logic [POS_W-1:0] pos,
                                            input logic [POS_W-1:0] vlen);
    if (pos >= POS_W'(SECT_BYTES)) return CL_SKIP;
    if (pos >= vlen)               return CL_PAD;
    return CL_APPLY;
  endfunction
endpackage

// File: rtl/ecc_report_decode.sv
module ecc_report_decode
  import ecc_fix_pkg::*;
#(
  parameter int N_FIX  = MAX_FIX,
  parameter int IDX_W  = $clog2(N_FIX + 1)
) (
  input  logic [WORD_W-1:0] loc_lo,
  input  logic [WORD_W-1:0] loc_hi,
  input  logic [WORD_W-1:0] pat,
  input  logic [POS_W-1:0]  vlen,
  input  logic [IDX_W-1:0]  idx,
  output logic [CNT_W-1:0]  count,
  output logic [POS_W-1:0]  pos,
  output logic [PAT_W-1:0]  xpat,
  output entry_class_e      cls
);
  localparam int SEL_W = (N_FIX > 1) ? $clog2(N_FIX) : 1;

  logic [POS_W-1:0] pos_arr [N_FIX];
  logic [PAT_W-1:0] pat_arr [N_FIX];
  logic [SEL_W-1:0] sel;

  generate
    for (genvar g = 0; g < N_FIX; g++) begin : g_entry
      if (g < 2) begin : g_lo
        assign pos_arr[g] = half_pos(loc_lo, 1'(g % 2));
      end else begin : g_hi
        assign pos_arr[g] = half_pos(loc_hi, 1'(g % 2));
      end
      assign pat_arr[g] = pat[g*PAT_W +: PAT_W];
    end
  endgenerate

  assign sel   = (idx < IDX_W'(N_FIX)) ? SEL_W'(idx) : '0;
  assign count = report_count(loc_lo);
  assign pos   = pos_arr[sel];
  assign xpat  = pat_arr[sel];
  assign cls   = classify(pos_arr[sel], vlen);
endmodule

// File: rtl/ecc_sector_buf.sv
module ecc_sector_buf
  import ecc_fix_pkg::*;
#(
  parameter int DEPTH  = SECT_BYTES,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_waddr,
  input  logic [PAT_W-1:0]  host_wdata,
  input  logic [ADDR_W-1:0] host_raddr,
  output logic [PAT_W-1:0]  host_rdata,
  input  logic              fix_re,
  input  logic              fix_we,
  input  logic [ADDR_W-1:0] fix_addr,
  input  logic [PAT_W-1:0]  fix_wdata,
  output logic [PAT_W-1:0]  fix_rdata
);
  logic [PAT_W-1:0] mem [DEPTH];
  logic [PAT_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (fix_we)       mem[fix_addr]   <= fix_wdata;
    else if (host_we) mem[host_waddr] <= host_wdata;
    if (fix_re)       rd_q            <= mem[fix_addr];
  end

  assign fix_rdata  = rd_q;
  assign host_rdata = mem[host_raddr];
endmodule

// File: rtl/ecc_fix_seq.sv
module ecc_fix_seq
  import ecc_fix_pkg::*;
#(
  parameter int N_FIX = MAX_FIX,
  parameter int IDX_W = $clog2(N_FIX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  entry_class_e     cls,
  output logic             busy,
  output logic             capture,
  output logic             rd_en,
  output logic             wr_en,
  output logic [IDX_W-1:0] idx,
  output logic             done,
  output fix_status_e      status
);
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_WRITE} seq_state_e;

  seq_state_e  state_q, state_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic        fin;
  fix_status_e fin_st;
  logic        done_q;
  fix_status_e st_q;

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    capture = 1'b0;
    rd_en   = 1'b0;
    wr_en   = 1'b0;
    fin     = 1'b0;
    fin_st  = ST_CLEAN;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          capture = 1'b1;
          idx_n   = '0;
          state_n = S_EVAL;
        end
      end
      S_EVAL: begin
        if (count == '0) begin
          fin = 1'b1; fin_st = ST_CLEAN;
        end else if (count > CNT_W'(N_FIX)) begin
          fin = 1'b1; fin_st = ST_UNCORR;
        end else if (idx_q == IDX_W'(count)) begin
          fin = 1'b1; fin_st = ST_FIXED;
        end else begin
          unique case (cls)
            CL_APPLY: begin rd_en = 1'b1; state_n = S_WRITE; end
            CL_PAD:   begin fin = 1'b1; fin_st = ST_CLEAN; end
            default:  idx_n = idx_q + 1'b1;
          endcase
        end
      end
      S_WRITE: begin
        wr_en   = 1'b1;
        idx_n   = idx_q + 1'b1;
        state_n = S_EVAL;
      end
      default: state_n = S_IDLE;
    endcase
    if (fin) state_n = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
      st_q    <= ST_CLEAN;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      done_q  <= fin;
      if (fin) st_q <= fin_st;
    end
  end

  assign busy   = (state_q != S_IDLE);
  assign idx    = idx_q;
  assign done   = done_q;
  assign status = st_q;

  // R9: a buffer read is always followed by its write-back
  assert_read_then_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> wr_en);
  // R2: no write-back for a zero or out-of-range count
  assert_no_write_uncorr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (count != '0 && count <= CNT_W'(N_FIX)));
  // R9: done lasts one cycle and ends the busy period
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R11: status moves only with done
  assert_status_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || $stable(status)));
endmodule

// File: rtl/sector_ecc_fix.sv
module sector_ecc_fix
  import ecc_fix_pkg::*;
#(
  parameter int DEPTH  = SECT_BYTES,
  parameter int N_FIX  = MAX_FIX,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int IDX_W  = $clog2(N_FIX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       err_loc_lo,
  input  logic [31:0]       err_loc_hi,
  input  logic [31:0]       err_pat,
  input  logic [9:0]        valid_len,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_waddr,
  input  logic [7:0]        host_wdata,
  input  logic [ADDR_W-1:0] host_raddr,
  output logic [7:0]        host_rdata
);
  logic [WORD_W-1:0] lo_q, hi_q, pat_q;
  logic [POS_W-1:0]  len_q;
  logic              capture, rd_en, wr_en;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  count;
  logic [POS_W-1:0]  pos;
  logic [PAT_W-1:0]  xpat;
  entry_class_e      cls;
  logic [PAT_W-1:0]  old_byte;
  logic              host_we_ok;
  fix_status_e       st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      pat_q <= '0;
      len_q <= '0;
    end else if (capture) begin
      lo_q  <= err_loc_lo;
      hi_q  <= err_loc_hi;
      pat_q <= err_pat;
      len_q <= valid_len;
    end
  end

  ecc_report_decode #(.N_FIX(N_FIX), .IDX_W(IDX_W)) u_decode (
    .loc_lo (lo_q),
    .loc_hi (hi_q),
    .pat    (pat_q),
    .vlen   (len_q),
    .idx    (idx),
    .count  (count),
    .pos    (pos),
    .xpat   (xpat),
    .cls    (cls)
  );

  ecc_fix_seq #(.N_FIX(N_FIX), .IDX_W(IDX_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .count   (count),
    .cls     (cls),
    .busy    (busy),
    .capture (capture),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .idx     (idx),
    .done    (done),
    .status  (st)
  );

  assign host_we_ok = host_we && !busy;

  ecc_sector_buf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_buf (
    .clk        (clk),
    .host_we    (host_we_ok),
    .host_waddr (host_waddr),
    .host_wdata (host_wdata),
    .host_raddr (host_raddr),
    .host_rdata (host_rdata),
    .fix_re     (rd_en),
    .fix_we     (wr_en),
    .fix_addr   (ADDR_W'(pos)),
    .fix_wdata  (old_byte ^ xpat),
    .fix_rdata  (old_byte)
  );

  assign status = st;

  // R5: write-backs stay inside the valid payload
  assert_write_in_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (pos < len_q));
  // R10: a start during a walk does not disturb the captured report
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(lo_q) && $stable(hi_q) && $stable(pat_q)));
endmodule

// File: tb/sector_ecc_fix_bench.sv
module sector_ecc_fix_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] err_loc_lo = '0, err_loc_hi = '0, err_pat = '0;
  logic [9:0]  valid_len = 10'd512;
  logic        busy, done;
  logic [1:0]  status;
  logic        host_we = 1'b0;
  logic [8:0]  host_waddr = '0, host_raddr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;

  int checks = 0, errors = 0, cyc = 0;
  bit loaded = 0;

  // model state
  int m_mem [NB];
  int kq[$], pq[$], vq[$];
  bit m_done = 0;
  int m_status = 0;

  sector_ecc_fix u_sector_ecc_fix (
    .clk(clk), .rst_n(rst_n), .start(start),
    .err_loc_lo(err_loc_lo), .err_loc_hi(err_loc_hi), .err_pat(err_pat),
    .valid_len(valid_len), .busy(busy), .done(done), .status(status),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input int cnt, input int pa, input int pb);
    return (32'(cnt) << 26) | (32'(pb) << 16) | 32'(pa);
  endfunction

  // behavioural plan of one report: kind 0 idle cycle, 1 xor write, 2 finish
  task automatic plan(input logic [31:0] lo, input logic [31:0] hi,
                      input logic [31:0] pt, input int len);
    int cnt, p, b;
    cnt = int'(lo[28:26]);
    if (cnt == 0 || cnt > 4) begin
      kq.push_back(2); pq.push_back(0); vq.push_back(cnt == 0 ? 0 : 2);
      return;
    end
    for (int n = 0; n < cnt; n++) begin
      case (n)
        0: p = int'(lo[9:0]);
        1: p = int'(lo[25:16]);
        2: p = int'(hi[9:0]);
        default: p = int'(hi[25:16]);
      endcase
      b = int'((pt >> (8*n)) & 32'hFF);
      if (p >= NB) begin
        kq.push_back(0); pq.push_back(0); vq.push_back(0);
      end else if (p >= len) begin
        kq.push_back(2); pq.push_back(0); vq.push_back(0);
        return;
      end else begin
        kq.push_back(0); pq.push_back(0); vq.push_back(0);
        kq.push_back(1); pq.push_back(p); vq.push_back(b);
      end
    end
    kq.push_back(2); pq.push_back(0); vq.push_back(1);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      kq.delete(); pq.delete(); vq.delete();
      m_done = 0; m_status = 0;
    end else begin
      m_done = 0;
      if (kq.size() != 0) begin
        int k, p, v;
        k = kq.pop_front(); p = pq.pop_front(); v = vq.pop_front();
        if (k == 1) m_mem[p] = m_mem[p] ^ v;
        else if (k == 2) begin m_done = 1; m_status = v; end
      end else begin
        if (host_we) m_mem[host_waddr] = int'(host_wdata);
        if (start) plan(err_loc_lo, err_loc_hi, err_pat, int'(valid_len));
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (kq.size() != 0), "R9 busy", busy, kq.size() != 0);
      chk(done == m_done, "R9 done", done, m_done);
      chk(int'(status) == m_status, "R11 status", status, m_status);
      if (loaded)
        chk(int'(host_rdata) == m_mem[host_raddr], "R5 buffer byte",
            host_rdata, m_mem[host_raddr]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic rd(input int a, output int v);
    host_raddr = 9'(a);
    #1;
    v = int'(host_rdata);
  endtask

  task automatic run(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] pt,
                     input int len, input int exp_cyc, input int exp_st, input string tag);
    int n;
    @(negedge clk);
    err_loc_lo = lo; err_loc_hi = hi; err_pat = pt; valid_len = 10'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done) begin @(negedge clk); n++; end
    chk(n == exp_cyc, {tag, " R9 cycle count"}, n, exp_cyc);
    chk(int'(status) == exp_st, {tag, " status"}, status, exp_st);
  endtask

  initial begin
    int b0, b1, b2, b3, a;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && status == 2'b00, "R11 reset state",
        {busy, done, status}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      host_we = 1'b1; host_waddr = 9'(i); host_wdata = 8'((i*37 + 11) & 255);
    end
    @(negedge clk);
    host_we = 1'b0;
    loaded = 1;

    // R1: zero count, nothing touched
    rd(3, b0);
    run(mk(0, 3, 4), mk(0, 5, 6), 32'hFFFF_FFFF, 512, 2, 0, "R1");
    rd(3, a); chk(a == b0, "R1 byte 3 untouched", a, b0);

    // R2: counts 5 and 7 are uncorrectable
    rd(10, b0);
    run(mk(5, 10, 11), mk(0, 12, 13), 32'hFFFF_FFFF, 512, 2, 2, "R2");
    run(mk(7, 10, 11), mk(0, 12, 13), 32'hFFFF_FFFF, 512, 2, 2, "R2");
    rd(10, a); chk(a == b0, "R2 byte 10 untouched", a, b0);

    // R3 R4 R5: four corrections, fields and pattern bytes
    rd(1, b0); rd(200, b1); rd(300, b2); rd(511, b3);
    run(mk(4, 1, 200), mk(0, 300, 511), 32'h4433_2211, 512, 10, 1, "R5");
    rd(1, a);   chk(a == (b0 ^ 'h11), "R3 R4 error 1", a, b0 ^ 'h11);
    rd(200, a); chk(a == (b1 ^ 'h22), "R3 R4 error 2", a, b1 ^ 'h22);
    rd(300, a); chk(a == (b2 ^ 'h33), "R3 R4 error 3", a, b2 ^ 'h33);
    rd(511, a); chk(a == (b3 ^ 'h44), "R3 R4 error 4", a, b3 ^ 'h44);

    // R6: only the first count errors
    rd(40, b0); rd(41, b1); rd(42, b2); rd(43, b3);
    run(mk(2, 40, 41), mk(0, 42, 43), 32'h0804_0201, 512, 6, 1, "R6");
    rd(40, a); chk(a == (b0 ^ 1), "R6 first", a, b0 ^ 1);
    rd(41, a); chk(a == (b1 ^ 2), "R6 second", a, b1 ^ 2);
    rd(42, a); chk(a == b2, "R6 third untouched", a, b2);
    rd(43, a); chk(a == b3, "R6 fourth untouched", a, b3);

    // R8: 512 and 1023 skipped, walk continues
    rd(10, b0); rd(11, b1);
    run(mk(3, 512, 10), mk(0, 1023, 11), 32'h0000_5A00, 512, 6, 1, "R8");
    rd(10, a); chk(a == (b0 ^ 'h5A), "R8 after skip", a, b0 ^ 'h5A);
    rd(11, a); chk(a == b1, "R8 beyond count", a, b1);

    // R7 R12: 44-byte payload, padding stops the walk
    rd(5, b0); rd(6, b1);
    run(mk(4, 5, 100), mk(0, 6, 7), 32'h0404_0303, 44, 4, 0, "R7");
    rd(5, a); chk(a == (b0 ^ 3), "R7 earlier kept", a, b0 ^ 3);
    rd(6, a); chk(a == b1, "R7 later not applied", a, b1);
    rd(43, b0);
    run(mk(2, 43, 44), mk(0, 0, 0), 32'h0000_7700, 44, 4, 0, "R12");
    rd(43, a); chk(a == b0, "R12 pattern 1 is zero", a, b0);
    run(mk(1, 43, 0), mk(0, 0, 0), 32'h0000_0081, 44, 4, 1, "R12");
    rd(43, a); chk(a == (b0 ^ 'h81), "R12 last valid byte", a, b0 ^ 'h81);

    // R5: repeated position compounds
    rd(77, b0);
    run(mk(2, 77, 77), mk(0, 0, 0), 32'h0000_F00F, 512, 6, 1, "R5 dup");
    rd(77, a); chk(a == (b0 ^ 'hFF), "R5 duplicate", a, b0 ^ 'hFF);

    // R10: start and host write ignored while busy
    rd(20, b0); rd(30, b1); rd(31, b2);
    @(negedge clk);
    err_loc_lo = mk(1, 30, 0); err_loc_hi = '0; err_pat = 32'h0000_0010; valid_len = 10'd512;
    start = 1'b1;
    @(negedge clk);
    err_loc_lo = mk(1, 31, 0); err_pat = 32'h0000_00FF;
    host_we = 1'b1; host_waddr = 9'd20; host_wdata = ~8'(b0);
    chk(busy == 1'b1, "R10 busy after start", busy, 1);
    @(negedge clk);
    start = 1'b0; host_we = 1'b0;
    while (!done) @(negedge clk);
    chk(int'(status) == 1, "R10 status", status, 1);
    rd(20, a); chk(a == b0, "R10 host write ignored", a, b0);
    rd(30, a); chk(a == (b1 ^ 'h10), "R10 first report applied", a, b1 ^ 'h10);
    rd(31, a); chk(a == b2, "R10 second start ignored", a, b2);

    // R11: status held while idle
    repeat (6) @(negedge clk);
    chk(int'(status) == 1 && !done, "R11 status held", status, 1);
    run(mk(6, 0, 0), mk(0, 0, 0), 32'h0, 512, 2, 2, "R11 next");

    // final sweep of the whole buffer
    for (int i = 0; i < NB; i++) begin
      rd(i, a);
      chk(a == m_mem[i], "R5 final sweep", a, m_mem[i]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule